// File: doc/BRIEF.md
# Zero-Crossing Stereo Gain Updater

This block sits between the control registers and the input gain stage of a stereo audio path. Software writes a new gain value for the left or right channel. The block does not pass that value straight through. It holds the value as pending and applies it only at a moment when the channel's signal is at or through zero, so the step in gain causes no audible click. If no zero crossing arrives in time, a shared timeout applies the pending value anyway. Each channel has a status flag that software reads: 0 means a gain change is still waiting, and 1 means it has settled.

A power-down pin resets the block. When the pin is released, a fixed initialisation period of sample ticks runs, and both flags read 0 until it ends. Several mode inputs change how the flags behave. The flags read 1 while the power-management enable is low, while zero-cross mode is off, and while an automatic level-control mode owns the gain. In each case where the zero-cross path is not in use, a write takes effect at the next clock edge.

All pending writes share one timeout counter. A rewrite to a channel that is still waiting does not restart that counter. A write that finds its channel already settled does restart it, and this also lengthens the wait of the other channel if that channel is still pending.

Top module: `zcg_gain_updater`

## Requirements
- R1: While `pd_n` is low, after the next clock edge both gains equal `GAIN_RST` (default 8'h10), and both flags read 0 if `pwr_en` is 1.
- R2: While `pwr_en` is 0, both flags read 1 regardless of any other state or input.
- R3: After `pd_n` rises with `pwr_en`=1, the flags read 0 until `INIT_TICKS` (default 4096) ticks of `smp_tick` have been counted after the first edge that sees `pd_n` high. They read 1 from the edge on which the last of those ticks is taken.
- R4: In zero-cross mode (`zc_en`=1, `indep_en`=1, `alc_on`=0), a write to a channel clears that channel's flag to 0 at the next edge and leaves its applied gain unchanged.
- R5: A pending channel applies its stored gain, and its flag returns to 1, on an edge where `smp_tick` is 1 and either the channel's sample is zero or the sign bit (MSB, two's complement) differs from the sample taken at the previous tick. A channel with nothing pending keeps its gain.
- R6: If no zero crossing occurs, all pending gains apply on the N-th counted tick after the last timer restart, where `tmo_sel` 0/1/2/3 gives N = 128/256/512/1024. A tick taken in the same cycle as a restart is not counted.
- R7: A rewrite to a channel that is still pending replaces the stored value but does not restart the timeout counter.
- R8: A zero-cross-mode write to a channel whose flag is 1 restarts the timeout counter, even while the other channel is pending. The other channel then also waits a full period from this write.
- R9: With `zc_en`=0, or with `indep_en`=0, a write applies to the gain at the next edge. With `zc_en`=0 the flags read 1.
- R10: While `alc_on` is 1, both flags read 1, writes apply at the next edge, and any gain still pending applies at the next edge.
- R11: Gain writes made while `pd_n` is low or during initialisation are ignored; the gains stay at `GAIN_RST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_n | input | 1 | Power-down pin, active low |
| pwr_en | input | 1 | Power-management enable; 0 forces both flags to 1 |
| zc_en | input | 1 | Zero-cross update mode enable |
| indep_en | input | 1 | Independent left/right gain update enable |
| alc_on | input | 1 | Automatic level-control active (either automatic mode) |
| tmo_sel | input | 2 | Timeout length select: 128 << tmo_sel ticks |
| smp_tick | input | 1 | One-cycle strobe per audio sample |
| smp_l | input | SW (16) | Left channel signed sample |
| smp_r | input | SW (16) | Right channel signed sample |
| wr_l | input | 1 | Write strobe for the left gain |
| wr_r | input | 1 | Write strobe for the right gain |
| wr_gain | input | GW (8) | Gain value for the write |
| gain_l | output | GW (8) | Applied left gain |
| gain_r | output | GW (8) | Applied right gain |
| flag_l | output | 1 | Left status flag, 1 = settled |
| flag_r | output | 1 | Right status flag, 1 = settled |

## Verification
Properties checked on every clock cycle cover the following. Flags are forced high by the power-management bit and by level-control mode, and held low during power-down and initialisation. Gains reset on power-down. A gain is held while a zero-cross write waits. A gain never moves while nothing is pending. A write in direct mode lands at once. Whether the shared timer was restarted or left running, and the exact tick on which a timeout or initialisation completes, depend on the history of writes and ticks. Only the bench's timed scenarios can show these, because they count ticks against 128-, 256- and 4096-tick windows and place rewrites of pending and settled channels inside them.

// File: rtl/zcg_pkg.sv
package zcg_pkg;

    // Block phase after the power-down pin
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_INIT = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    // Status flag seen by software for one channel
    function automatic logic chan_flag(
        input logic pm_on,
        input logic running,
        input logic zc_on,
        input logic alc,
        input logic pending
    );
        if (!pm_on)         return 1'b1;
        if (!running)       return 1'b0;
        if (!zc_on || alc)  return 1'b1;
        return !pending;
    endfunction

endpackage

// File: rtl/zcg_zc_detect.sv
module zcg_zc_detect #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [SW-1:0] sample,
    output logic          zc
);

    typedef struct packed {
        logic sign;
        logic valid;
    } det_t;

    det_t det_q, det_d;
    logic cur_sign;
    logic is_zero;

    assign cur_sign = sample[SW-1];
    assign is_zero  = (sample == '0);

    // crossing: zero sample, or sign flip against the previous tick's sample
    assign zc = tick && (is_zero || (det_q.valid && (cur_sign != det_q.sign)));

    always_comb begin
        det_d = det_q;
        if (clr) begin
            det_d.valid = 1'b0;
            det_d.sign  = 1'b0;
        end else if (tick) begin
            det_d.valid = 1'b1;
            det_d.sign  = cur_sign;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

endmodule

// File: rtl/zcg_tick_timer.sv
module zcg_tick_timer #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          expire
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] cnt_inc;

    assign cnt_inc = cnt_q + ONE;
    // restart wins over a tick taken in the same cycle
    assign expire  = run && !restart && (cnt_inc == limit);

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = expire ? '0 : cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/zcg_gain_updater.sv
module zcg_gain_updater
    import zcg_pkg::*;
#(
    parameter int            GW         = 8,
    parameter int            SW         = 16,
    parameter int            INIT_TICKS = 4096,
    parameter int            TMO_BASE   = 128,
    parameter logic [GW-1:0] GAIN_RST   = GW'(16)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pd_n,
    input  logic          pwr_en,
    input  logic          zc_en,
    input  logic          indep_en,
    input  logic          alc_on,
    input  logic [1:0]    tmo_sel,
    input  logic          smp_tick,
    input  logic [SW-1:0] smp_l,
    input  logic [SW-1:0] smp_r,
    input  logic          wr_l,
    input  logic          wr_r,
    input  logic [GW-1:0] wr_gain,
    output logic [GW-1:0] gain_l,
    output logic [GW-1:0] gain_r,
    output logic          flag_l,
    output logic          flag_r
);

    localparam int NCH     = 2;
    localparam int TMO_MAX = TMO_BASE << 3;
    localparam int MAXL    = (INIT_TICKS > TMO_MAX) ? INIT_TICKS : TMO_MAX;
    localparam int CW      = $clog2(MAXL) + 1;

    typedef struct packed {
        phase_e                  phase;
        logic [NCH-1:0][GW-1:0]  gain;
        logic [NCH-1:0][GW-1:0]  tgt;
        logic [NCH-1:0]          pend;
    } st_t;

    st_t st_q, st_d;

    logic [NCH-1:0]          wr_vec;
    logic [NCH-1:0][SW-1:0]  smp_vec;
    logic [NCH-1:0]          zc_vec;
    logic [NCH-1:0]          flag_vec;

    logic          zc_mode;
    logic          running;
    logic          tmr_restart;
    logic          tmr_run;
    logic          tmr_expire;
    logic [CW-1:0] tmr_limit;

    // exposed for the bound checker
    logic           run_phase;
    logic [NCH-1:0] pend_vec;

    assign wr_vec  = {wr_r, wr_l};
    assign smp_vec = {smp_r, smp_l};

    assign running   = (st_q.phase == PH_RUN);
    assign zc_mode   = zc_en && indep_en && !alc_on;
    assign run_phase = running;
    assign pend_vec  = st_q.pend;

    // ---------------- per-channel zero-crossing detectors ----------------
    for (genvar g = 0; g < NCH; g++) begin : g_det
        zcg_zc_detect #(
            .SW(SW)
        ) u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (!pd_n),
            .tick   (smp_tick),
            .sample (smp_vec[g]),
            .zc     (zc_vec[g])
        );
    end

    // ---------------- shared timer: init period and timeout ----------------
    // a write restarts the timer only if it finds its channel settled
    assign tmr_restart = (st_q.phase == PH_OFF) ||
                         (running && pd_n && zc_mode && |(wr_vec & ~st_q.pend));
    assign tmr_run     = smp_tick && ((st_q.phase == PH_INIT) || (running && |st_q.pend));
    assign tmr_limit   = (st_q.phase == PH_INIT) ? CW'(INIT_TICKS)
                                                 : (CW'(TMO_BASE) << tmo_sel);

    zcg_tick_timer #(
        .CW(CW)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .run     (tmr_run),
        .limit   (tmr_limit),
        .expire  (tmr_expire)
    );

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        if (!pd_n) begin
            st_d.phase = PH_OFF;
            st_d.pend  = '0;
            for (int c = 0; c < NCH; c++) begin
                st_d.gain[c] = GAIN_RST;
            end
        end else begin
            unique case (st_q.phase)
                PH_OFF: begin
                    st_d.phase = PH_INIT;
                end
                PH_INIT: begin
                    if (tmr_expire) begin
                        st_d.phase = PH_RUN;
                    end
                end
                PH_RUN: begin
                    for (int c = 0; c < NCH; c++) begin
                        if (wr_vec[c]) begin
                            if (zc_mode) begin
                                st_d.tgt[c]  = wr_gain;
                                st_d.pend[c] = 1'b1;
                            end else begin
                                st_d.gain[c] = wr_gain;
                                st_d.pend[c] = 1'b0;
                            end
                        end else if (st_q.pend[c] &&
                                     (zc_vec[c] || tmr_expire || !zc_mode)) begin
                            st_d.gain[c] = st_q.tgt[c];
                            st_d.pend[c] = 1'b0;
                        end
                    end
                end
                default: begin
                    st_d.phase = PH_OFF;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_OFF;
            st_q.gain  <= {NCH{GAIN_RST}};
            st_q.tgt   <= {NCH{GAIN_RST}};
            st_q.pend  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- outputs ----------------
    for (genvar g = 0; g < NCH; g++) begin : g_flag
        assign flag_vec[g] = chan_flag(pwr_en, running, zc_en, alc_on, st_q.pend[g]);
    end

    assign gain_l = st_q.gain[0];
    assign gain_r = st_q.gain[1];
    assign flag_l = flag_vec[0];
    assign flag_r = flag_vec[1];

endmodule

// File: rtl/zcg_gain_updater_chk.sv
module zcg_gain_updater_chk #(
    parameter int            GW       = 8,
    parameter logic [GW-1:0] GAIN_RST = GW'(16)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pd_n,
    input logic          pwr_en,
    input logic          zc_en,
    input logic          indep_en,
    input logic          alc_on,
    input logic          wr_l,
    input logic          wr_r,
    input logic [GW-1:0] wr_gain,
    input logic [GW-1:0] gain_l,
    input logic [GW-1:0] gain_r,
    input logic          flag_l,
    input logic          flag_r,
    input logic          run_phase,
    input logic [1:0]    pend_vec
);

    logic zc_mode;
    assign zc_mode = zc_en && indep_en && !alc_on;

    p_pd_gain_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (gain_l == GAIN_RST && gain_r == GAIN_RST));

    p_pd_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (!pwr_en || (!flag_l && !flag_r)));

    p_pm_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> (flag_l && flag_r));

    p_init_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_phase && pwr_en) |-> (!flag_l && !flag_r));

    p_zc_hold_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_phase && pd_n && zc_mode && wr_l) |=> (gain_l == $past(gain_l)));

    p_zc_hold_r_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_phase && pd_n && zc_mode && wr_r) |=> (gain_r == $past(gain_r)));

    p_idle_l_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_phase && pd_n && zc_mode && !pend_vec[0]) |=> $stable(gain_l));

    p_idle_r_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_phase && pd_n && zc_mode && !pend_vec[1]) |=> $stable(gain_r));

    p_direct_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_phase && pd_n && !zc_mode && wr_l) |=> (gain_l == $past(wr_gain)));

    p_alc_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_phase && alc_on) |-> (flag_l && flag_r));

    p_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_phase && pd_n) |=> ($stable(gain_l) && $stable(gain_r)));

endmodule

bind zcg_gain_updater zcg_gain_updater_chk #(
    .GW       (GW),
    .GAIN_RST (GAIN_RST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_n      (pd_n),
    .pwr_en    (pwr_en),
    .zc_en     (zc_en),
    .indep_en  (indep_en),
    .alc_on    (alc_on),
    .wr_l      (wr_l),
    .wr_r      (wr_r),
    .wr_gain   (wr_gain),
    .gain_l    (gain_l),
    .gain_r    (gain_r),
    .flag_l    (flag_l),
    .flag_r    (flag_r),
    .run_phase (run_phase),
    .pend_vec  (pend_vec)
);

// File: tb/zcg_gain_updater_test.sv
module zcg_gain_updater_test;

    localparam logic [7:0] RST = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n, pd_n, pwr_en, zc_en, indep_en, alc_on;
    logic [1:0]  tmo_sel;
    logic        smp_tick;
    logic [15:0] smp_l, smp_r;
    logic        wr_l, wr_r;
    logic [7:0]  wr_gain;
    logic [7:0]  gain_l, gain_r;
    logic        flag_l, flag_r;

    always #5 clk = ~clk;

    zcg_gain_updater uut (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .pwr_en(pwr_en),
        .zc_en(zc_en), .indep_en(indep_en), .alc_on(alc_on),
        .tmo_sel(tmo_sel), .smp_tick(smp_tick), .smp_l(smp_l), .smp_r(smp_r),
        .wr_l(wr_l), .wr_r(wr_r), .wr_gain(wr_gain),
        .gain_l(gain_l), .gain_r(gain_r), .flag_l(flag_l), .flag_r(flag_r)
    );

    typedef struct {
        int         cyc;
        logic [7:0] gl;
        logic [7:0] gr;
        logic       fl;
        logic       fr;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc   = 0;
    int   nchk  = 0;
    int   nfail = 0;
    bit   done  = 0;

    task automatic expect_at(int off, logic [7:0] gl, logic [7:0] gr,
                             logic fl, logic fr, string tag);
        exp_t e;
        e.cyc = cyc + off; e.gl = gl; e.gr = gr; e.fl = fl; e.fr = fr; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    // monitor: compares outputs mid-cycle against queued expectations
    initial begin
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                exp_t e;
                e = q.pop_front();
                nchk++;
                if (gain_l !== e.gl || gain_r !== e.gr || flag_l !== e.fl || flag_r !== e.fr) begin
                    nfail++;
                    $display("FAIL %s cyc=%0d actual gl=%h gr=%h fl=%b fr=%b expected gl=%h gr=%h fl=%b fr=%b",
                             e.tag, cyc, gain_l, gain_r, flag_l, flag_r, e.gl, e.gr, e.fl, e.fr);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(200000 * 10);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired at cyc=%0d", cyc);
            summary();
        end
    end

    // driver
    initial begin
        rst_n = 0; pd_n = 0; pwr_en = 1; zc_en = 1; indep_en = 1; alc_on = 0;
        tmo_sel = 2'd0; smp_tick = 0; smp_l = 16'd100; smp_r = 16'd100;
        wr_l = 0; wr_r = 0; wr_gain = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state, R11 write in power-down
        @(negedge clk);
        expect_at(1, RST, RST, 0, 0, "R1 reset state");
        wr_l = 1; wr_gain = 8'h55;
        @(negedge clk);
        wr_l = 0;
        expect_at(1, RST, RST, 0, 0, "R11 write during power-down");
        @(negedge clk);
        pwr_en = 0;
        expect_at(1, RST, RST, 1, 1, "R2 power-management off");
        @(negedge clk);
        pwr_en = 1;

        // R3 initialisation, R11 write during init
        pd_n = 1; smp_tick = 1;
        expect_at(4096, RST, RST, 0, 0, "R3 still initialising");
        expect_at(4097, RST, RST, 1, 1, "R3 init done, R11 init write ignored");
        repeat (10) @(negedge clk);
        wr_r = 1; wr_gain = 8'h66;
        @(negedge clk);
        wr_r = 0;
        repeat (4086) @(negedge clk);
        smp_tick = 0;

        // R4 zero-cross write, R5 sign change
        @(negedge clk);
        wr_l = 1; wr_gain = 8'h21;
        expect_at(1, RST, RST, 0, 1, "R4 left pending");
        @(negedge clk);
        wr_l = 0; smp_l = -16'sd5; smp_tick = 1;
        expect_at(1, 8'h21, RST, 1, 1, "R5 sign change applies");
        @(negedge clk);
        smp_tick = 0;

        // R5 zero sample
        wr_r = 1; wr_gain = 8'h33;
        expect_at(1, 8'h21, RST, 1, 0, "R4 right pending");
        @(negedge clk);
        wr_r = 0; smp_r = 16'd0; smp_tick = 1;
        expect_at(1, 8'h21, 8'h33, 1, 1, "R5 zero sample applies");
        @(negedge clk);
        smp_tick = 0; smp_r = 16'd100;

        // R6 timeout 128
        @(negedge clk);
        tmo_sel = 2'd0; wr_l = 1; wr_gain = 8'h40;
        expect_at(128, 8'h21, 8'h33, 0, 1, "R6 still pending at 127 ticks");
        expect_at(129, 8'h40, 8'h33, 1, 1, "R6 timeout 128");
        @(negedge clk);
        wr_l = 0; smp_tick = 1;
        repeat (128) @(negedge clk);
        smp_tick = 0;

        // R6 timeout 256
        tmo_sel = 2'd1; wr_r = 1; wr_gain = 8'h44;
        expect_at(256, 8'h40, 8'h33, 1, 0, "R6 still pending at 255 ticks");
        expect_at(257, 8'h40, 8'h44, 1, 1, "R6 timeout 256");
        @(negedge clk);
        wr_r = 0; smp_tick = 1;
        repeat (256) @(negedge clk);
        smp_tick = 0;

        // R7 rewrite of a pending channel keeps the timer
        tmo_sel = 2'd0; wr_l = 1; wr_gain = 8'h50;
        expect_at(128, 8'h40, 8'h44, 0, 1, "R7 pending before expiry");
        expect_at(129, 8'h51, 8'h44, 1, 1, "R7 rewrite got remaining period");
        @(negedge clk);
        wr_l = 0; smp_tick = 1;
        repeat (60) @(negedge clk);
        wr_l = 1; wr_gain = 8'h51;
        @(negedge clk);
        wr_l = 0;
        repeat (67) @(negedge clk);
        smp_tick = 0;

        // R8 write to settled channel restarts the shared timer
        wr_l = 1; wr_gain = 8'h60;
        expect_at(129, 8'h51, 8'h44, 0, 0, "R8 left not applied at old deadline");
        expect_at(189, 8'h51, 8'h44, 0, 0, "R8 both pending before new deadline");
        expect_at(190, 8'h60, 8'h70, 1, 1, "R8 both apply after restart");
        @(negedge clk);
        wr_l = 0; smp_tick = 1;
        repeat (60) @(negedge clk);
        wr_r = 1; wr_gain = 8'h70;
        @(negedge clk);
        wr_r = 0;
        repeat (128) @(negedge clk);
        smp_tick = 0;

        // R9 direct modes
        zc_en = 0; wr_l = 1; wr_gain = 8'h11;
        expect_at(1, 8'h11, 8'h70, 1, 1, "R9 zero-cross off applies at once");
        @(negedge clk);
        wr_l = 0; zc_en = 1; indep_en = 0; wr_r = 1; wr_gain = 8'h12;
        expect_at(1, 8'h11, 8'h12, 1, 1, "R9 joint update applies at once");
        @(negedge clk);
        wr_r = 0; indep_en = 1;

        // R10 level-control modes
        alc_on = 1; wr_l = 1; wr_gain = 8'h13;
        expect_at(1, 8'h13, 8'h12, 1, 1, "R10 write under level control");
        @(negedge clk);
        wr_l = 0; alc_on = 0; wr_r = 1; wr_gain = 8'h77;
        expect_at(1, 8'h13, 8'h12, 1, 0, "R4 right pending before level control");
        @(negedge clk);
        wr_r = 0; alc_on = 1;
        expect_at(1, 8'h13, 8'h77, 1, 1, "R10 pending applied and flags forced");
        @(negedge clk);
        alc_on = 0;

        // R1 power-down from run, R2
        pd_n = 0;
        expect_at(1, RST, RST, 0, 0, "R1 power-down resets gains and flags");
        @(negedge clk);
        pwr_en = 0;
        expect_at(1, RST, RST, 1, 1, "R2 flags high in power-down");
        repeat (3) @(negedge clk);

        if (q.size() != 0) begin
            nfail++;
            $display("FAIL scoreboard left %0d expectations unchecked", q.size());
        end
        done = 1;
        summary();
    end

endmodule